// File: doc/BRIEF.md
# I/O Privilege and Port Permission Checker

This block decides whether an I/O-sensitive instruction may go ahead or must raise a general protection fault (exception 13). The request carries the current privilege level, the processor flags word, a one-bit class (flag-only instruction or port instruction), the port number and the access width. Flag-only instructions (interrupt enable, interrupt disable, bus lock prefix) are judged on the I/O privilege level alone. Port instructions that fail the level test fall back to a per-port permission bitmap held inside the task state segment.

The bitmap is read one byte at a time through a simple read port addressed by the byte offset within the task segment. The bitmap starts at an offset supplied with the request, and any byte whose offset lies beyond the task segment limit counts as all ones. A multi-byte access checks every port it covers, so an access whose ports straddle a byte boundary needs a second fetch. Each accepted request ends in exactly one single-cycle pulse, either allow or fault.

Top module: `ioPermCheck`

## Requirements
- R1: After reset, busy, rdReq, doneOk and doneFault are all low.
- R2: The I/O privilege level is flagsWord bits 14:13; when cpl is less than or equal to it, an accepted request of either class pulses doneOk in the cycle after acceptance without any bitmap read.
- R3: A flag-only request (reqPort = 0) with cpl greater than the I/O privilege level pulses doneFault in the cycle after acceptance without any bitmap read.
- R4: A port request (reqPort = 1) with cpl greater than the I/O privilege level reads the byte at offset bmapOffset + portNum/8 and tests bit portNum mod 8; a 0 allows and a 1 faults, and with a read port that answers one cycle after rdReq the result pulses three cycles after acceptance.
- R5: accWidth 0 covers one port, 1 covers two ports, 2 and 3 cover four ports (portNum upward); any covered bit at 1 faults.
- R6: When the covered bits run past bit 7 of the first byte and the first byte is clean, the next byte (offset + 1) is read and its covered low bits are tested; the result pulses five cycles after acceptance.
- R7: A bitmap byte whose offset is greater than tssLimit is treated as all ones without a read: fault two cycles after acceptance when it is the first byte, four cycles when it is the second; a byte at an offset equal to tssLimit is read normally.
- R8: doneOk and doneFault are never high together, and each accepted request yields exactly one result pulse.
- R9: busy is high while a bitmap check is in progress, a request presented while busy is ignored, and busy is low in the cycle of a result pulse.
- R10: rdReq stays high with rdAddr unchanged until rdValid is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; accepted when busy is low |
| reqPort | input | 1 | 1 = port instruction, 0 = flag-only instruction |
| cpl | input | 2 | Current privilege level |
| flagsWord | input | FLAG_W | Flags word; bits 14:13 hold the I/O privilege level |
| portNum | input | PORT_W | First port number of the access |
| accWidth | input | 2 | Access width code (0 byte, 1 word, 2/3 doubleword) |
| bmapOffset | input | OFS_W | Byte offset of the bitmap within the task segment |
| tssLimit | input | ADDR_W | Last valid byte offset of the task segment |
| rdReq | output | 1 | Bitmap byte read request |
| rdAddr | output | ADDR_W | Byte offset of the requested bitmap byte |
| rdData | input | 8 | Returned bitmap byte |
| rdValid | input | 1 | rdData valid for the pending read |
| busy | output | 1 | Bitmap check in progress |
| doneOk | output | 1 | One-cycle pulse: access allowed |
| doneFault | output | 1 | One-cycle pulse: exception 13 |

## Verification
Each result has a fixed due cycle counted from the accepting edge: one cycle for any decision made on the privilege level alone, two or four cycles when the first or second bitmap byte lies past the limit, and three or five cycles when a decision follows one or two reads from a port that answers one cycle after its request. The driver computes the expected verdict, due cycle and read count from the requirements and queues them; the monitor samples on the falling edge, counts reads, and on each result pulse compares verdict, elapsed cycles and reads against the queued entry. A pulse with nothing queued, or a request slipped in while busy that produces a result, is reported against the overlap and exclusivity requirements.

// File: rtl/iopPkg.sv
package iopPkg;
  localparam int IOPL_LSB = 13;
  localparam int SPAN_W   = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK0 = 2'd1,
    ST_CHK1 = 2'd2
  } iopState_t;

  typedef struct packed {
    logic load;   // capture request fields
    logic sel1;   // address / test the second bitmap byte
  } ctlStrobe_t;
endpackage

// File: rtl/iopDatapath.sv
module iopDatapath
  import iopPkg::*;
#(
  parameter int PORT_W = 16,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        cpl,
  input  logic [FLAG_W-1:0] flagsWord,
  input  logic [PORT_W-1:0] portNum,
  input  logic [1:0]        accWidth,
  input  logic [OFS_W-1:0]  bmapOffset,
  input  logic [ADDR_W-1:0] tssLimit,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              levelOk,
  output logic              beyondCur,
  output logic              hitCur,
  output logic              spanCross
);
  logic [1:0]        ioplVal;
  logic              unusedFlagBits;
  logic [3:0]        lenMask;
  logic [SPAN_W-1:0] spanNext;
  logic [ADDR_W-1:0] offNext;
  logic [SPAN_W-1:0] spanR;
  logic [ADDR_W-1:0] off0R;
  logic [ADDR_W-1:0] limitR;
  logic [7:0]        maskCur;

  assign ioplVal        = flagsWord[IOPL_LSB+1:IOPL_LSB];
  assign unusedFlagBits = ^{flagsWord[FLAG_W-1:IOPL_LSB+2], flagsWord[IOPL_LSB-1:0]};
  assign levelOk        = (cpl <= ioplVal);

  always_comb begin
    case (accWidth)
      2'd0:    lenMask = 4'b0001;
      2'd1:    lenMask = 4'b0011;
      default: lenMask = 4'b1111;
    endcase
  end

  assign spanNext = SPAN_W'(lenMask) << portNum[2:0];
  assign offNext  = ADDR_W'(bmapOffset) + ADDR_W'(portNum >> 3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spanR  <= '0;
      off0R  <= '0;
      limitR <= '0;
    end else if (strobe.load) begin
      spanR  <= spanNext;
      off0R  <= offNext;
      limitR <= tssLimit;
    end
  end

  assign rdAddr    = strobe.sel1 ? off0R + ADDR_W'(1) : off0R;
  assign maskCur   = strobe.sel1 ? spanR[SPAN_W-1:8] : spanR[7:0];
  assign beyondCur = (rdAddr > limitR);
  assign hitCur    = |(rdData & maskCur);
  assign spanCross = |spanR[SPAN_W-1:8];
endmodule

// File: rtl/iopControl.sv
module iopControl
  import iopPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqPort,
  input  logic       levelOk,
  input  logic       beyondCur,
  input  logic       hitCur,
  input  logic       spanCross,
  input  logic       rdValid,
  output ctlStrobe_t strobe,
  output logic       rdReq,
  output logic       busy,
  output logic       doneOk,
  output logic       doneFault
);
  iopState_t state, nextState;
  logic okNext, faultNext;

  always_comb begin
    nextState   = state;
    strobe      = '0;
    strobe.sel1 = (state == ST_CHK1);
    okNext      = 1'b0;
    faultNext   = 1'b0;
    rdReq       = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          if (levelOk)       okNext    = 1'b1;
          else if (!reqPort) faultNext = 1'b1;
          else               nextState = ST_CHK0;
        end
      end
      ST_CHK0, ST_CHK1: begin
        if (beyondCur) begin
          faultNext = 1'b1;
          nextState = ST_IDLE;
        end else begin
          rdReq = 1'b1;
          if (rdValid) begin
            if (hitCur) begin
              faultNext = 1'b1;
              nextState = ST_IDLE;
            end else if (state == ST_CHK0 && spanCross) begin
              nextState = ST_CHK1;
            end else begin
              okNext    = 1'b1;
              nextState = ST_IDLE;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneOk    <= 1'b0;
      doneFault <= 1'b0;
    end else begin
      state     <= nextState;
      doneOk    <= okNext;
      doneFault <= faultNext;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ioPermCheck.sv
module ioPermCheck
  import iopPkg::*;
#(
  parameter int PORT_W = 16,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqPort,
  input  logic [1:0]        cpl,
  input  logic [FLAG_W-1:0] flagsWord,
  input  logic [PORT_W-1:0] portNum,
  input  logic [1:0]        accWidth,
  input  logic [OFS_W-1:0]  bmapOffset,
  input  logic [ADDR_W-1:0] tssLimit,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  input  logic              rdValid,
  output logic              busy,
  output logic              doneOk,
  output logic              doneFault
);
  ctlStrobe_t strobe;
  logic levelOk, beyondCur, hitCur, spanCross;

  iopDatapath #(
    .PORT_W(PORT_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpl(cpl), .flagsWord(flagsWord),
    .portNum(portNum), .accWidth(accWidth), .bmapOffset(bmapOffset),
    .tssLimit(tssLimit), .rdData(rdData), .rdAddr(rdAddr), .levelOk(levelOk),
    .beyondCur(beyondCur), .hitCur(hitCur), .spanCross(spanCross)
  );

  iopControl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .levelOk(levelOk), .beyondCur(beyondCur), .hitCur(hitCur),
    .spanCross(spanCross), .rdValid(rdValid), .strobe(strobe), .rdReq(rdReq),
    .busy(busy), .doneOk(doneOk), .doneFault(doneFault)
  );
endmodule

// File: rtl/iopChecker.sv
module iopChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqPort,
  input logic [1:0]        cpl,
  input logic [1:0]        iopl,
  input logic              busy,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdValid,
  input logic              doneOk,
  input logic              doneFault
);
  AST_LEVEL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy && (cpl <= iopl) |=> doneOk && !rdReq); // R2
  AST_FLAG_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy && !reqPort && (cpl > iopl) |=> doneFault && !rdReq); // R3
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq); // R4
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && doneFault)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (doneOk || doneFault) |-> !busy); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdValid |=> rdReq && $stable(rdAddr)); // R10
endmodule

bind ioPermCheck iopChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort), .cpl(cpl),
  .iopl(flagsWord[iopPkg::IOPL_LSB+1:iopPkg::IOPL_LSB]), .busy(busy),
  .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .doneOk(doneOk),
  .doneFault(doneFault)
);

// File: tb/sim_ioPermCheck.sv
`timescale 1ns/1ps
module sim_ioPermCheck;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqPort = 1'b0;
  logic [1:0]  cpl = '0, accWidth = '0;
  logic [31:0] flagsWord = '0, tssLimit = '0;
  logic [15:0] portNum = '0, bmapOffset = '0;
  logic        rdReq, rdValid, busy, doneOk, doneFault;
  logic [31:0] rdAddr;
  logic [7:0]  rdData;
  logic [7:0]  mem [256];

  int cyc = 0, checks = 0, fails = 0, acceptCyc = 0, readCnt = 0;
  bit finished = 0;
  logic [31:0] lastAddr = '0;
  bit   expOkQ[$];
  int   expLatQ[$], expRdQ[$];
  string tagQ[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  ioPermCheck u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort), .cpl(cpl),
    .flagsWord(flagsWord), .portNum(portNum), .accWidth(accWidth),
    .bmapOffset(bmapOffset), .tssLimit(tssLimit), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .doneOk(doneOk),
    .doneFault(doneFault)
  );

  // bitmap memory: answers one cycle after a request
  always @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdReq && !rdValid;
      rdData  <= mem[rdAddr[7:0]];
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: reads, address hold, verdict and due cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rdValid) begin
        readCnt++;
        check("R10", rdAddr == lastAddr, rdAddr, lastAddr, "read address held");
      end
      if (rdReq) lastAddr = rdAddr;
      if (rstN && (doneOk || doneFault)) begin
        check("R8", !(doneOk && doneFault), {doneOk, doneFault}, 0, "exclusive verdict");
        if (expOkQ.size() == 0) begin
          check("R8", 0, 1, 0, "unexpected result pulse");
        end else begin
          bit eOk; int eLat, eRd; string tg;
          eOk = expOkQ.pop_front(); eLat = expLatQ.pop_front();
          eRd = expRdQ.pop_front(); tg = tagQ.pop_front();
          check(tg, doneOk == eOk, doneOk, eOk, "verdict (1=allow)");
          check(tg, (cyc - acceptCyc + 1) == eLat, cyc - acceptCyc + 1, eLat, "cycles to result");
          check(tg, readCnt == eRd, readCnt, eRd, "bitmap reads");
          check("R9", !busy, busy, 0, "busy at result");
        end
        readCnt = 0;
      end
    end
  end

  // expected outcome from the requirements
  task automatic model(input bit isPort, input int c, input int io, input int port,
                       input int w, input int ofs, input int lim,
                       output bit ok, output int lat, output int rd);
    int n, b, o0, lastBit;
    bit hit;
    if (c <= io) begin ok = 1; lat = 1; rd = 0; return; end
    if (!isPort) begin ok = 0; lat = 1; rd = 0; return; end
    n = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    b = port % 8; o0 = ofs + port / 8; lastBit = b + n - 1;
    if (o0 > lim) begin ok = 0; lat = 2; rd = 0; return; end
    hit = 0;
    for (int i = b; i <= lastBit && i < 8; i++) hit |= mem[o0][i];
    if (hit) begin ok = 0; lat = 3; rd = 1; return; end
    if (lastBit < 8) begin ok = 1; lat = 3; rd = 1; return; end
    if (o0 + 1 > lim) begin ok = 0; lat = 4; rd = 1; return; end
    for (int i = 0; i <= lastBit - 8; i++) hit |= mem[o0 + 1][i];
    ok = !hit; lat = 5; rd = 2;
  endtask

  task automatic send(input string tag, input bit isPort, input int c, input int io,
                      input int port, input int w, input int ofs, input int lim,
                      input bit injectBusy);
    bit eOk; int eLat, eRd;
    model(isPort, c, io, port, w, ofs, lim, eOk, eLat, eRd);
    expOkQ.push_back(eOk); expLatQ.push_back(eLat); expRdQ.push_back(eRd); tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1; reqPort = isPort; cpl = 2'(c); accWidth = 2'(w);
    flagsWord = 32'hFFFF_FFFF; flagsWord[14:13] = 2'(io);
    portNum = 16'(port); bmapOffset = 16'(ofs); tssLimit = 32'(lim);
    acceptCyc = cyc + 1;
    @(negedge clk);
    reqValid = 0;
    if (injectBusy) begin
      // R9: a flag-only request that would fault at level 3 vs 0, offered while busy
      check("R9", busy == 1, busy, 1, "busy during bitmap check");
      reqValid = 1; reqPort = 0; cpl = 2'd3; flagsWord[14:13] = 2'd0;
      @(negedge clk);
      reqValid = 0;
    end
    while (expOkQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h20] = 8'h01;   // port 0 denied
    mem[8'h21] = 8'h80;   // port 15 denied
    mem[8'h23] = 8'h11;   // ports 0x18 and 0x1C denied
    repeat (3) @(negedge clk);
    check("R1", !busy && !rdReq && !doneOk && !doneFault, {busy, rdReq, doneOk, doneFault}, 0, "outputs in reset");
    rstN = 1;
    @(negedge clk);
    check("R1", !busy && !rdReq && !doneOk && !doneFault, {busy, rdReq, doneOk, doneFault}, 0, "outputs after reset");

    send("R2", 0, 0, 0, 0, 0, 'h20, 'h3F, 0);        // flag-only, equal levels
    send("R2", 1, 2, 3, 0, 0, 'h20, 'h3F, 0);        // port denied in map, level wins
    send("R3", 0, 3, 1, 0, 0, 'h20, 'h3F, 0);        // flag-only fault
    send("R4", 1, 3, 0, 1, 0, 'h20, 'h3F, 0);        // clear bit, allow
    send("R4", 1, 3, 0, 0, 0, 'h20, 'h3F, 0);        // set bit, fault
    send("R5", 1, 3, 0, 14, 1, 'h20, 'h3F, 0);       // word covers port 15
    send("R5", 1, 1, 0, 'h10, 2, 'h20, 'h3F, 0);     // dword clean
    send("R5", 1, 3, 2, 'h1A, 3, 'h20, 'h3F, 0);     // code 3 = four ports, hits 0x1C
    send("R5", 1, 3, 2, 'h1A, 1, 'h20, 'h3F, 0);     // word stops before 0x1C
    send("R6", 1, 3, 0, 'h26, 2, 'h20, 'h3F, 0);     // straddle, both clean
    send("R6", 1, 3, 0, 'h17, 1, 'h20, 'h3F, 0);     // straddle, second byte hits
    send("R7", 1, 3, 0, 'h200, 0, 'h20, 'h3F, 0);    // first byte past limit
    send("R7", 1, 3, 0, 'h27, 1, 'h20, 'h24, 0);     // second byte past limit
    send("R7", 1, 3, 0, 'h20, 0, 'h20, 'h24, 0);     // byte exactly at limit
    send("R9", 1, 3, 0, 'h26, 2, 'h20, 'h3F, 1);     // request while busy ignored
    check("R8", expOkQ.size() == 0, expOkQ.size(), 0, "results outstanding");
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule